// File: doc/BRIEF.md
# Framed Serial Port with Frame-Sync Ignore

This block is one synchronous serial channel that receives and transmits at the same time. It takes a bit clock, a frame-sync pulse and a serial data input, and it produces a serial data output. Everything is sampled by the chip's system clock. Bits move most-significant first. Incoming bits are taken on the falling bit-clock edge, and outgoing bits change on the rising edge. The first bit of an element follows the bit period in which frame sync was seen high.

An element is 8 or 32 bits long. A control pin picks what happens when frame sync arrives in the middle of an element. The block can let the element run on, or it can abort the element, raise a sticky sync-error flag and start again on the new frame. If the element length is 32 and the ignore pin is set, a stream of 8-bit frames packs into 32-bit words. The parallel side then does one transfer for every four frames.

The parallel side is a receive holding register and a transmit holding register, each with a valid/ready handshake.
- Receive holding register: the block raises `rx_valid`, and the word leaves in a cycle where `rx_ready` is high. There is no back-pressure on the serial line. If an element completes while the holding register is still full and not being read in that cycle, the new word is dropped.
- Transmit holding register: `tx_ready` is high while it is empty, and a word is taken in a cycle where `tx_valid` and `tx_ready` are both high. If an element must start with no word waiting, the previous word is sent again.

Top module: `fsp_port`

## Requirements
- R1: After reset, `rx_valid`=0, `tx_ready`=1, `sdout`=0, and all three flags are 0.
- R2: Bits are sent and received MSB first. The receiver samples `sdin` on falling `bclk` edges, and the transmitter updates `sdout` on rising edges. The first data bit is the one sampled at the falling edge after the falling edge where `fsync` was seen high. An 8-bit element appears on `rx_data[7:0]` with bits 31:8 zero, and only `tx_data[7:0]` is sent.
- R3: With `cfg_ignore`=0, every completed element produces one receive copy and one transmit load. A frame sync sampled on the last bit of an element starts the next element back to back, and this is not an error.
- R4: With `cfg_ignore`=1, a frame sync that arrives before the last bit has no effect. With `cfg_wide`=1, four 8-bit frames then give exactly one 32-bit receive word and use one transmit word.
- R5: With `cfg_ignore`=0, a frame sync before the last bit sets `sync_err`. The partial element is discarded, and a new element starts from that sync.
- R6: `sync_err` stays set until `flag_clr[0]` is pulsed high.
- R7: If an element completes while `rx_valid`=1 and `rx_ready`=0, then `rx_overrun` is set and `rx_data` keeps the old word.
- R8: If an element completes in the same cycle as a receive read, the new word is captured and no overrun is flagged.
- R9: If an element starts while the transmit holding register is empty, then `tx_underrun` is set and the previous word is sent again. That word is 0 if no word has been sent since reset.
- R10: `tx_ready` is high exactly when the transmit holding register is empty. An accepted word is sent in the next element that starts.
- R11: `flag_clr` bit 0 clears `sync_err`, bit 1 clears `rx_overrun` and bit 2 clears `tx_underrun`. Each bit clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Serial bit clock, sampled by clk |
| fsync | input | 1 | Frame-sync pulse |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| cfg_wide | input | 1 | 1 = 32-bit elements, 0 = 8-bit elements |
| cfg_ignore | input | 1 | 1 = ignore early frame sync, 0 = abort and flag |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_data | output | 32 | Receive word |
| tx_valid | input | 1 | Producer offers a transmit word |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_data | input | 32 | Transmit word |
| sync_err | output | 1 | Sticky early-frame-sync error |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_underrun | output | 1 | Sticky transmit underrun |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags |

## Verification
Two events can land in the same system cycle: an element completing on a falling bit-clock edge and a parallel read of the receive holding register. The bench keeps the first word unread through a second back-to-back frame. It then raises `rx_ready` in exactly the cycle where the falling edge of the final bit is detected. The test passes only if the popped value is the first word, the holding register then shows the second word, and `rx_overrun` stays 0. A separate run without the read must show the overrun flag set and the old word kept.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  parameter int WORD_W   = 32;
  parameter int NARROW_W = 8;
  localparam int CNT_W   = $clog2(WORD_W);

  localparam int FLAG_SYNC = 0;
  localparam int FLAG_OVR  = 1;
  localparam int FLAG_UND  = 2;
  localparam int FLAG_N    = 3;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic sample;    // falling edge inside an element
    logic done;      // falling edge on the last bit
    logic load;      // a new element begins after this edge
    logic abort;     // early sync with ignore clear
    logic drive;     // rising edge inside an element
    logic idle_rise; // rising edge outside any element
  } frame_ev_t;

  function automatic word_t left_align(word_t w, logic wide);
    if (wide) return w;
    return {w[NARROW_W-1:0], {(WORD_W-NARROW_W){1'b0}}};
  endfunction
endpackage

// File: rtl/fsp_frame_trk.sv
module fsp_frame_trk
  import fsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bclk,
  input  logic      fsync,
  input  logic      cfg_wide,
  input  logic      cfg_ignore,
  input  logic      clr_sync,
  output frame_ev_t ev,
  output logic      sync_err
);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(NARROW_W - 1);

  logic             bclk_q;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             fall, rise, last, early;

  assign fall  = bclk_q & ~bclk;
  assign rise  = ~bclk_q & bclk;
  assign last  = (cnt == (cfg_wide ? LAST_WIDE : LAST_NARROW));
  assign early = active & ~last & fsync;

  always_comb begin
    ev.sample    = fall & active;
    ev.done      = fall & active & last;
    ev.abort     = fall & early & ~cfg_ignore;
    ev.load      = fall & fsync & (~active | last | ~cfg_ignore);
    ev.drive     = rise & active;
    ev.idle_rise = rise & ~active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      bclk_q <= bclk;
      if (ev.load) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (ev.done) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (ev.sample) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_err <= 1'b0;
    end else begin
      if (clr_sync) sync_err <= 1'b0;
      if (ev.abort) sync_err <= 1'b1;
    end
  end

  // R4: an ignored early sync leaves the element counting on
  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && early && cfg_ignore) |=> (active && cnt == CNT_W'($past(cnt) + 1'b1)));

  // R5: an early sync with ignore clear flags and restarts at bit 0
  p_abort_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev.abort |=> (sync_err && active && cnt == '0));

  // R6: the error flag holds until its clear pulse
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && !clr_sync) |=> sync_err);

  // R2: the bit counter never passes the element length
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= (cfg_wide ? LAST_WIDE : LAST_NARROW)));
endmodule

// File: rtl/fsp_rx_path.sv
module fsp_rx_path
  import fsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  frame_ev_t ev,
  input  logic      sdin,
  input  logic      rx_ready,
  input  logic      clr_ovr,
  output logic      rx_valid,
  output word_t     rx_data,
  output logic      rx_overrun
);
  word_t sh;
  word_t word_in;
  logic  pop;

  assign word_in = {sh[WORD_W-2:0], sdin};
  assign pop     = rx_valid & rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (ev.done || ev.abort) begin
      sh <= '0;
    end else if (ev.sample) begin
      sh <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      rx_overrun <= 1'b0;
    end else begin
      if (clr_ovr) rx_overrun <= 1'b0;
      if (ev.done) begin
        if (!rx_valid || pop) begin
          rx_valid <= 1'b1;
          rx_data  <= word_in;
        end else begin
          rx_overrun <= 1'b1;
        end
      end else if (pop) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R7: completion into a full, unread register keeps the old word
  p_keep_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.done && rx_valid && !rx_ready) |=> (rx_overrun && $stable(rx_data)));

  // R8: completion alongside a read refills the register
  p_pop_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.done && rx_valid && rx_ready) |=> (rx_valid && !$rose(rx_overrun)));
endmodule

// File: rtl/fsp_tx_path.sv
module fsp_tx_path
  import fsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  frame_ev_t ev,
  input  logic      cfg_wide,
  input  logic      tx_valid,
  input  word_t     tx_data,
  input  logic      clr_und,
  output logic      tx_ready,
  output logic      sdout,
  output logic      tx_underrun
);
  logic  hold_valid;
  word_t hold_data;
  word_t last_word;
  word_t tsh;
  logic  accept;

  assign tx_ready = ~hold_valid;
  assign accept   = tx_valid & ~hold_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid  <= 1'b0;
      hold_data   <= '0;
      last_word   <= '0;
      tx_underrun <= 1'b0;
    end else begin
      if (clr_und) tx_underrun <= 1'b0;
      if (accept) begin
        hold_valid <= 1'b1;
        hold_data  <= tx_data;
      end
      if (ev.load) begin
        if (hold_valid) begin
          hold_valid <= 1'b0;
          last_word  <= hold_data;
        end else begin
          tx_underrun <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsh   <= '0;
      sdout <= 1'b0;
    end else if (ev.load) begin
      tsh <= left_align(hold_valid ? hold_data : last_word, cfg_wide);
    end else if (ev.drive) begin
      sdout <= tsh[WORD_W-1];
      tsh   <= {tsh[WORD_W-2:0], 1'b0};
    end else if (ev.idle_rise) begin
      sdout <= 1'b0;
    end
  end

  // R9: starting with nothing written raises the underrun flag
  p_underrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load && !hold_valid) |=> tx_underrun);

  // R10: an accepted word closes the handshake until it is loaded
  p_accept_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/fsp_port.sv
module fsp_port
  import fsp_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                sdin,
  output logic                sdout,
  input  logic                cfg_wide,
  input  logic                cfg_ignore,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [WORD_W-1:0]   rx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [WORD_W-1:0]   tx_data,
  output logic                sync_err,
  output logic                rx_overrun,
  output logic                tx_underrun,
  input  logic [FLAG_N-1:0]   flag_clr
);
  frame_ev_t ev;

  fsp_frame_trk u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .fsync      (fsync),
    .cfg_wide   (cfg_wide),
    .cfg_ignore (cfg_ignore),
    .clr_sync   (flag_clr[FLAG_SYNC]),
    .ev         (ev),
    .sync_err   (sync_err)
  );

  fsp_rx_path u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .sdin       (sdin),
    .rx_ready   (rx_ready),
    .clr_ovr    (flag_clr[FLAG_OVR]),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_overrun (rx_overrun)
  );

  fsp_tx_path u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev          (ev),
    .cfg_wide    (cfg_wide),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .clr_und     (flag_clr[FLAG_UND]),
    .tx_ready    (tx_ready),
    .sdout       (sdout),
    .tx_underrun (tx_underrun)
  );

  // R11: each clear bit drops only its own flag
  p_clr_only_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr == 3'b010 && tx_underrun) |=> tx_underrun);
endmodule

// File: tb/fsp_port_tb_top.sv
module fsp_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
  logic        cfg_wide = 1'b0, cfg_ignore = 1'b0;
  logic        rx_ready = 1'b0, tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic [2:0]  flag_clr = '0;
  logic        sdout, rx_valid, tx_ready, sync_err, rx_overrun, tx_underrun;
  logic [31:0] rx_data;

  int ntot = 0, nbad = 0;
  bit finished = 0;

  logic din_a [0:127];
  logic fs_a  [0:127];
  logic cap_a [0:127];

  always #10 clk = ~clk;

  fsp_port dut_i (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdin(sdin),
    .sdout(sdout), .cfg_wide(cfg_wide), .cfg_ignore(cfg_ignore),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sync_err(sync_err), .rx_overrun(rx_overrun), .tx_underrun(tx_underrun),
    .flag_clr(flag_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_stream();
    for (int i = 0; i < 128; i++) begin
      din_a[i] = 1'b0; fs_a[i] = 1'b0; cap_a[i] = 1'b0;
    end
  endtask

  task automatic put_bits(input int off, input int n, input logic [31:0] w);
    for (int i = 0; i < n; i++) din_a[off+i] = w[n-1-i];
  endtask

  function automatic logic [31:0] get_cap(input int off, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r = {r[30:0], cap_a[off+i]};
    return r;
  endfunction

  // one bit period: rise, then fall; sdout sampled just before the fall
  task automatic bit_cycle(input logic fs, input logic d, input int k,
                           input int wr_k, input logic [31:0] wr_w,
                           input int pop_k, inout logic [31:0] popped);
    @(negedge clk);
    fsync = fs; sdin = d; bclk = 1'b1;
    if (k == wr_k) begin tx_valid = 1'b1; tx_data = wr_w; end
    @(negedge clk);
    tx_valid = 1'b0;
    @(negedge clk);
    if (k >= 0) cap_a[k] = sdout;
    if (k == pop_k) begin popped = rx_data; rx_ready = 1'b1; end
    bclk = 1'b0;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic run_stream(input int nbits, input int wr_k, input logic [31:0] wr_w,
                            input int pop_k, output logic [31:0] popped);
    popped = '0;
    bit_cycle(1'b1, 1'b0, -1, wr_k, wr_w, pop_k, popped);
    for (int k = 0; k < nbits; k++)
      bit_cycle(fs_a[k], din_a[k], k, wr_k, wr_w, pop_k, popped);
    for (int j = 0; j < 3; j++)
      bit_cycle(1'b0, 1'b0, -2, wr_k, wr_w, pop_k, popped);
    fsync = 1'b0; sdin = 1'b0;
  endtask

  task automatic write_tx(input logic [31:0] w);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(output logic [31:0] w);
    @(negedge clk);
    w = rx_data; rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 rx_valid", {31'b0, rx_valid}, 32'd0);
    chk("R1 tx_ready", {31'b0, tx_ready}, 32'd1);
    chk("R1 sdout", {31'b0, sdout}, 32'd0);
    chk("R1 flags", {29'b0, sync_err, rx_overrun, tx_underrun}, 32'd0);
  endtask

  task automatic t_narrow_b2b();
    logic [31:0] p, w;
    cfg_wide = 1'b0; cfg_ignore = 1'b0;
    clear_stream();
    write_tx(32'hFFFF_FFA1);
    put_bits(0, 8, 32'h11); put_bits(8, 8, 32'h22);
    fs_a[7] = 1'b1;
    run_stream(16, 2, 32'h0000_00B2, 15, p);
    chk("R2 tx first elem MSB first", get_cap(0, 8), 32'hA1);
    chk("R10 tx word written mid-element", get_cap(8, 8), 32'hB2);
    chk("R3 back-to-back no sync error", {31'b0, sync_err}, 32'd0);
    chk("R3 no underrun with two words", {31'b0, tx_underrun}, 32'd0);
    chk("R8 popped first word", p, 32'h11);
    chk("R2 second word zero-extended", rx_data, 32'h22);
    chk("R8 holding refilled", {31'b0, rx_valid}, 32'd1);
    chk("R8 no overrun", {31'b0, rx_overrun}, 32'd0);
    pop_rx(w);
    chk("R3 one copy per element", {31'b0, rx_valid}, 32'd0);
  endtask

  task automatic t_overrun();
    logic [31:0] p, w;
    cfg_wide = 1'b0; cfg_ignore = 1'b0;
    clear_flags(3'b111);
    clear_stream();
    put_bits(0, 8, 32'h33); put_bits(8, 8, 32'h44);
    fs_a[7] = 1'b1;
    run_stream(16, -5, 32'h0, -5, p);
    chk("R7 old word kept", rx_data, 32'h33);
    chk("R7 overrun set", {31'b0, rx_overrun}, 32'd1);
    chk("R9 underrun with no write", {31'b0, tx_underrun}, 32'd1);
    clear_flags(3'b010);
    chk("R11 overrun cleared", {31'b0, rx_overrun}, 32'd0);
    chk("R11 underrun untouched", {31'b0, tx_underrun}, 32'd1);
    pop_rx(w);
  endtask

  task automatic t_underrun();
    logic [31:0] p, w;
    cfg_wide = 1'b0; cfg_ignore = 1'b0;
    clear_flags(3'b111);
    clear_stream();
    write_tx(32'h0000_003C);
    fs_a[7] = 1'b1;
    run_stream(16, -5, 32'h0, -5, p);
    chk("R9 first element", get_cap(0, 8), 32'h3C);
    chk("R9 repeated last word", get_cap(8, 8), 32'h3C);
    chk("R9 underrun flag", {31'b0, tx_underrun}, 32'd1);
    pop_rx(w);
    clear_flags(3'b111);
  endtask

  task automatic t_pack();
    logic [31:0] p, w;
    cfg_wide = 1'b1; cfg_ignore = 1'b1;
    clear_flags(3'b111);
    clear_stream();
    write_tx(32'hDEAD_BEEF);
    put_bits(0, 32, 32'h1234_5678);
    fs_a[7] = 1'b1; fs_a[15] = 1'b1; fs_a[23] = 1'b1;
    run_stream(32, -5, 32'h0, -5, p);
    chk("R4 packed rx word", rx_data, 32'h1234_5678);
    chk("R4 packed tx word", get_cap(0, 32), 32'hDEAD_BEEF);
    chk("R4 no sync error", {31'b0, sync_err}, 32'd0);
    chk("R4 single tx load", {31'b0, tx_underrun}, 32'd0);
    pop_rx(w);
    chk("R4 one rx copy per 32 bits", {31'b0, rx_valid}, 32'd0);
  endtask

  task automatic t_ignore_narrow();
    logic [31:0] p, w;
    cfg_wide = 1'b0; cfg_ignore = 1'b1;
    clear_flags(3'b111);
    clear_stream();
    put_bits(0, 8, 32'hC5);
    fs_a[2] = 1'b1;
    run_stream(11, -5, 32'h0, -5, p);
    chk("R4 narrow ignored sync", rx_data, 32'hC5);
    chk("R4 narrow no error", {31'b0, sync_err}, 32'd0);
    pop_rx(w);
    chk("R4 narrow single word", {31'b0, rx_valid}, 32'd0);
  endtask

  task automatic t_sync_err();
    logic [31:0] p, w;
    cfg_wide = 1'b0; cfg_ignore = 1'b0;
    clear_flags(3'b111);
    clear_stream();
    put_bits(0, 3, 32'h7);
    put_bits(3, 8, 32'h69);
    fs_a[2] = 1'b1;
    run_stream(11, -5, 32'h0, -5, p);
    chk("R5 restarted element", rx_data, 32'h69);
    chk("R5 sync error set", {31'b0, sync_err}, 32'd1);
    pop_rx(w);
    chk("R5 partial discarded", {31'b0, rx_valid}, 32'd0);
    repeat (10) @(negedge clk);
    chk("R6 flag sticky", {31'b0, sync_err}, 32'd1);
    clear_flags(3'b001);
    chk("R6 flag cleared", {31'b0, sync_err}, 32'd0);
  endtask

  task automatic t_sync_err_wide();
    logic [31:0] p, w;
    cfg_wide = 1'b1; cfg_ignore = 1'b0;
    clear_flags(3'b111);
    clear_stream();
    put_bits(0, 8, 32'hFF);
    put_bits(8, 32, 32'hA5C3_0F96);
    fs_a[7] = 1'b1;
    run_stream(40, -5, 32'h0, -5, p);
    chk("R5 wide restart word", rx_data, 32'hA5C3_0F96);
    chk("R5 wide sync error", {31'b0, sync_err}, 32'd1);
    pop_rx(w);
    clear_flags(3'b111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++; ntot++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_b2b();
    t_overrun();
    t_underrun();
    t_pack();
    t_ignore_narrow();
    t_sync_err();
    t_sync_err_wide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule